// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block turns an asynchronous serial line back into characters. A configuration byte sets the frame format: seven or eight data bits, one of four parity modes, and an enable that is made of two bits. An external baud generator gives the block a sampling strobe at sixteen times the bit rate. The block finds each start bit, confirms it in the middle of the bit, and samples every later bit in its middle. It then checks the parity bit and the first stop bit.

Each finished character goes into an 8-bit receive buffer. Parity, framing and overrun errors build up in a status byte until software reads that byte. When a character completes, the block raises a single-cycle pulse. A clean character always pulses the receive interrupt. A character with an error pulses either the receive interrupt or a separate error interrupt, and a configuration bit picks which one.

The state machine has five states. IDLE waits for a low line. START confirms the start bit at mid-bit: if the line is back high it returns to IDLE, and if the line is still low it moves to DATA. DATA shifts in the data bits. It moves to PARITY when a parity mode is selected, and otherwise it moves to STOP. PARITY takes in the parity bit and moves to STOP. STOP samples the first stop bit, hands the character to the buffer and returns to IDLE. From any state, losing the enable forces a return to IDLE.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is received only while cfg bit 7 (clock enable) and cfg bit 5 (receive enable) are both 1. Otherwise the line is ignored: no interrupt is raised and rx_data is unchanged.
- R2: A falling edge starts a frame only if the line is still low on the 8th sampling strobe after the edge. A low pulse shorter than half a bit produces no character.
- R3: Data bits arrive LSB first. cfg bit 2 = 1 selects 8 data bits. cfg bit 2 = 0 selects 7 data bits, and rx_data bit 7 then reads 0.
- R4: cfg bits 4:3 select the parity mode: 00 none (no parity bit on the line), 01 zero (the parity bit must be 0), 10 odd, 11 even. A mismatch sets rx_status bit 2.
- R5: A first stop bit sampled low sets rx_status bit 1. Only the first stop bit is examined, so a second stop bit on the line is accepted without error.
- R6: If a character completes while the previous one has not been taken with buf_rd, rx_status bit 0 is set and the new character overwrites rx_data.
- R7: Error flags stay set until a stat_rd strobe clears them. rx_status bits 7:3 always read 0.
- R8: Each character raises a one-cycle pulse in the same cycle that rx_data updates. A clean character pulses irq_rx. A character with any error pulses irq_rx when cfg bit 0 = 1, and pulses irq_err when cfg bit 0 = 0. The two interrupts are never high together.
- R9: After reset, rx_data, rx_status, irq_rx and irq_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sampling strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg | input | 8 | Configuration byte |
| buf_rd | input | 1 | Strobe: receive buffer has been read |
| stat_rd | input | 1 | Strobe: status byte has been read (clears flags) |
| rx_data | output | 8 | Receive buffer |
| rx_status | output | 8 | Status byte: bit 2 parity, bit 1 framing, bit 0 overrun |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The assertions check, on every cycle, the rules that follow from the structure:
- the two interrupts are exclusive, and each is a single-cycle pulse;
- an error interrupt always comes with a non-zero status;
- flags stay sticky when no stat_rd arrives;
- the machine sits in IDLE while disabled;
- a character is handed over only from the stop state;
- the data-bit index stays within range.

The bench scenarios are the only way to show the following:
- data order and data values;
- the parity result for each of the four modes;
- rejection of a short glitch;
- overrun followed by an overwrite;
- routing of errors by cfg bit 0;
- that a disabled receiver leaves the buffer untouched.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_t;

    localparam int CFG_ROUTE  = 0;
    localparam int CFG_LEN8   = 2;
    localparam int CFG_PAR_LO = 3;
    localparam int CFG_RXEN   = 5;
    localparam int CFG_CLKEN  = 7;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          en,
    input  logic          len8,
    input  par_mode_t     pmode,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] sh;
    logic          acc, pbit, sample;
    logic [IW-1:0] last_idx;

    assign last_idx = len8 ? IW'(DW-1) : IW'(DW-2);
    assign sample   = tick && ((state == ST_START) ? (cnt == MID) : (cnt == LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!line) nxt = ST_START;
            ST_START:  if (sample) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (sample && idx == last_idx)
                           nxt = (pmode == PAR_NONE) ? ST_STOP : ST_PARITY;
            ST_PARITY: if (sample) nxt = ST_STOP;
            ST_STOP:   if (sample) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            acc  <= 1'b0;
            pbit <= 1'b0;
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en || state == ST_IDLE) cnt <= '0;
            else if (tick)               cnt <= sample ? '0 : cnt + 1'b1;
            if (en && sample) begin
                unique case (state)
                    ST_START: begin
                        idx <= '0;
                        sh  <= '0;
                        acc <= 1'b0;
                    end
                    ST_DATA: begin
                        sh  <= {line, sh[DW-1:1]};
                        acc <= acc ^ line;
                        idx <= idx + 1'b1;
                    end
                    ST_PARITY: pbit <= line;
                    ST_STOP: begin
                        done <= 1'b1;
                        ferr <= !line;
                        data <= len8 ? sh : {1'b0, sh[DW-1:1]};
                        unique case (pmode)
                            PAR_NONE: perr <= 1'b0;
                            PAR_ZERO: perr <= pbit;
                            PAR_ODD:  perr <= !(acc ^ pbit);
                            PAR_EVEN: perr <= acc ^ pbit;
                            default:  perr <= 1'b0;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == ST_IDLE); // R1
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_STOP); // R5
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> idx <= last_idx); // R3
endmodule

// File: rtl/srx_status.sv
module srx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          perr,
    input  logic          ferr,
    input  logic          route,
    input  logic          buf_rd,
    input  logic          stat_rd,
    output logic [DW-1:0] rx_data,
    output logic [2:0]    flags,
    output logic          irq_rx,
    output logic          irq_err
);
    logic full, ovr, any_err;

    assign ovr     = full && !buf_rd;
    assign any_err = perr || ferr || ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            rx_data <= '0;
            flags   <= '0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            irq_rx  <= done && (!any_err || route);
            irq_err <= done && any_err && !route;
            if (done) begin
                rx_data <= data;
                full    <= 1'b1;
            end else if (buf_rd) begin
                full    <= 1'b0;
            end
            flags <= (flags & {3{!stat_rd}}) | ({perr, ferr, ovr} & {3{done}});
        end
    end

    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx && irq_err)); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx); // R8
    AST_ERR_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> flags != 3'b000); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !stat_rd) |=> flags[2]); // R7
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic [7:0]    cfg,
    input  logic          buf_rd,
    input  logic          stat_rd,
    output logic [DW-1:0] rx_data,
    output logic [7:0]    rx_status,
    output logic          irq_rx,
    output logic          irq_err
);
    logic          line_s, en, done, perr, ferr;
    logic [DW-1:0] cdata;
    logic [2:0]    flags;
    logic          unused_cfg;

    assign en         = cfg[CFG_CLKEN] && cfg[CFG_RXEN];
    assign unused_cfg = ^{cfg[6], cfg[1]};

    srx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    srx_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s), .en(en),
        .len8(cfg[CFG_LEN8]),
        .pmode(par_mode_t'(cfg[CFG_PAR_LO +: 2])),
        .done(done), .data(cdata), .perr(perr), .ferr(ferr)
    );

    srx_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .data(cdata), .perr(perr),
        .ferr(ferr), .route(cfg[CFG_ROUTE]), .buf_rd(buf_rd),
        .stat_rd(stat_rd), .rx_data(rx_data), .flags(flags),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    assign rx_status = {5'b00000, flags};
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
    localparam int BP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] cfg = 8'h00;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic       buf_rd;
    logic [7:0] rx_data, rx_status;
    logic       irq_rx, irq_err;

    logic [11:0] exp_q[$];
    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int tcnt = 0;
    bit auto_read = 1'b1;
    bit ended = 1'b0;

    always #5 clk = ~clk;
    assign buf_rd = mon_rd | man_rd;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg(cfg),
        .buf_rd(buf_rd), .stat_rd(stat_rd), .rx_data(rx_data),
        .rx_status(rx_status), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always @(negedge clk) begin
        tcnt++;
        tick = (tcnt % 4 == 0);
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per interrupt pulse
    always @(negedge clk) begin
        stat_rd = 1'b0;
        mon_rd  = 1'b0;
        if (rst_n && (irq_rx || irq_err)) begin
            logic [11:0] e;
            irq_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected character", {24'h0, rx_data}, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rx_data == e[7:0], "R3 data", rx_data, e[7:0]);
                chk(rx_status[2] == e[10], "R4 parity flag", rx_status, e[10]);
                chk(rx_status[1] == e[9], "R5 framing flag", rx_status, e[9]);
                chk(rx_status[0] == e[8], "R6 overrun flag", rx_status, e[8]);
                chk(rx_status[7:3] == 5'b0, "R7 upper status", rx_status, 0);
                chk({irq_err, irq_rx} == (e[11] ? 2'b10 : 2'b01),
                    "R8 interrupt routing", {irq_err, irq_rx}, e[11] ? 2 : 1);
            end
            stat_rd = 1'b1;
            mon_rd  = auto_read;
        end
    end

    task automatic drive(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c, input logic [7:0] d, input bit bad_par,
                        input bit bad_stop, input bit exp_ove, input bit push);
        int nb;
        logic [7:0] dv;
        logic p, pe;
        nb = c[2] ? 8 : 7;
        dv = c[2] ? d : {1'b0, d[6:0]};
        case (c[4:3])
            2'b01:   p = 1'b0;
            2'b10:   p = ~^dv;
            2'b11:   p = ^dv;
            default: p = 1'b0;
        endcase
        p  = p ^ bad_par;
        pe = bad_par && (c[4:3] != 2'b00);
        if (push) exp_q.push_back({(pe | bad_stop | exp_ove) & ~c[0], pe, bad_stop, exp_ove, dv});
        cfg = c;
        drive(1'b0, BP);
        for (int i = 0; i < nb; i++) drive(dv[i], BP);
        if (c[4:3] != 2'b00) drive(p, BP);
        if (bad_stop) begin
            drive(1'b0, 40);
            drive(1'b1, BP - 40);
        end else begin
            drive(1'b1, BP);
        end
        if (c[1]) drive(1'b1, BP);
        drive(1'b1, 2 * BP);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen0;
        logic [7:0] d0;
        repeat (4) @(negedge clk);
        chk(rx_data == 8'h00, "R9 rx_data reset", rx_data, 0);
        chk(rx_status == 8'h00, "R9 status reset", rx_status, 0);
        chk(!irq_rx && !irq_err, "R9 irq reset", {irq_err, irq_rx}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(rx_data == 8'h00 && rx_status == 8'h00, "R9 after release", rx_status, 0);

        send(8'hA4, 8'h5A, 0, 0, 0, 1);   // R3 8-bit, no parity
        send(8'hBC, 8'hC3, 0, 0, 0, 1);   // R4 even
        send(8'hB0, 8'hD5, 0, 0, 0, 1);   // R3 7-bit, R4 odd
        send(8'hAC, 8'h0F, 0, 0, 0, 1);   // R4 zero parity good
        send(8'hAD, 8'h10, 1, 0, 0, 1);   // R4 zero parity bad, R8 route to rx
        send(8'hB4, 8'h77, 1, 0, 0, 1);   // R4 odd bad, R8 route to err
        send(8'hA4, 8'hE1, 0, 1, 0, 1);   // R5 framing
        send(8'hA6, 8'h99, 0, 0, 0, 1);   // R5 two stop bits accepted
        repeat (8) @(negedge clk);
        chk(rx_status == 8'h00, "R7 cleared by stat_rd", rx_status, 0);

        // R6 overrun
        auto_read = 1'b0;
        send(8'hA4, 8'h21, 0, 0, 0, 1);
        send(8'hA4, 8'h42, 0, 0, 1, 1);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        auto_read = 1'b1;
        send(8'hA4, 8'h63, 0, 0, 0, 1);

        // R2 glitch shorter than half a bit
        seen0 = irq_seen;
        drive(1'b0, 24);
        drive(1'b1, 3 * BP);
        chk(irq_seen == seen0, "R2 glitch ignored", irq_seen, seen0);
        send(8'hA4, 8'h3C, 0, 0, 0, 1);

        // R1 disabled receiver
        seen0 = irq_seen;
        d0 = rx_data;
        send(8'h84, 8'hAA, 0, 0, 0, 0);
        send(8'h24, 8'hBB, 0, 0, 0, 0);
        chk(irq_seen == seen0, "R1 no irq when disabled", irq_seen, seen0);
        chk(rx_data == d0, "R1 buffer untouched", rx_data, d0);
        cfg = 8'hA4;
        send(8'hA4, 8'hCC, 0, 0, 0, 1);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every character signalled", exp_q.size(), 0);
        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule